// File: doc/BRIEF.md
# EEPROM Write Buffer and Program Controller

This block sits behind a serial-bus slave front end in a byte-addressed non-volatile memory. When a write transaction opens, the front end hands over the start address. Data bytes then arrive one strobe at a time, and the block holds them in a small slot buffer. Nothing reaches the array until the front end reports the bus STOP. At that point the buffered bytes are issued as array write requests, one per clock. The block then holds a busy flag for a modelled program time. It also returns the updated value for the shared address counter.

The buffering rule is picked by a mode input, which is latched when the start address is loaded.
- With the mode input low (row mode), up to a full row of bytes is accepted. Only the low row-offset bits of the address advance, so the address wraps inside the row.
- With the mode input high (burst mode), a short run of bytes is accepted from any start address, and the run may cross a row boundary.

In either mode, extra bytes fall back onto earlier buffer slots in wrap order. A write-control input sampled at STOP blocks the whole commit. The program time is a parameter in clock cycles. It is doubled when a burst touches two address groups.

The controller has four states:
- `WB_IDLE` moves to `WB_COLLECT` when the address is loaded.
- `WB_COLLECT` stores bytes and restarts on a fresh address load. On STOP it goes to `WB_WRITE` if at least one byte is held and writes are allowed; otherwise it goes back to `WB_IDLE`.
- `WB_WRITE` scans every buffer slot and moves to `WB_WAIT` after the last slot.
- `WB_WAIT` returns to `WB_IDLE` when the program timer expires.

Top module: `eeprom_wrbuf`

## Requirements
- R1: After reset, `busy`, `arr_we` and `ptr_upd` are low.
- R2: With `mode_multi`=0, byte k of a transaction that starts at address A goes to address {A[7:3], (A[2:0]+k) mod 8}, so the upper 5 address bits never change.
- R3: With `mode_multi`=0 and more than 8 bytes, each extra byte replaces the buffered byte at its wrapped address, and only the last value per address is written.
- R4: With `mode_multi`=1, byte k (k<4) goes to address A+k modulo 256, from any start address and across row boundaries.
- R5: With `mode_multi`=1 and more than 4 bytes, byte k replaces byte k mod 4 and goes to address A+(k mod 4).
- R6: A committed transaction holds `busy` for 8 + T cycles, where T is `PROG_CYCLES`. In burst mode it holds `busy` for 8 + 2T cycles instead when the first and last written addresses differ in bits [7:2].
- R7: No array write occurs before STOP. `busy` rises only on the cycle after STOP is seen.
- R8: While `busy` is high, address loads, data bytes and STOP are ignored, with no extra writes and no extra program time.
- R9: If `write_ctl`=1 when STOP is seen, no array write occurs and `busy` stays low.
- R10: A transaction with no data byte ends at STOP without writing and without raising `busy`.
- R11: One cycle after STOP is seen in a transaction, `ptr_upd` pulses with `ptr_value` set to the address that follows the last written byte. In row mode that is {A[7:3], (A[2:0]+n) mod 8}; in burst mode it is A+min(n,4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_addr | input | 1 | Start-address strobe that opens a write transaction |
| start_addr | input | 8 | Byte address of the first data byte |
| mode_multi | input | 1 | 1 = burst mode (4-byte limit), 0 = row mode (8-byte row); latched with the address |
| byte_valid | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | 8 | Data byte |
| stop_seen | input | 1 | One-cycle strobe for a bus STOP |
| write_ctl | input | 1 | 1 = array protected, sampled at STOP |
| arr_we | output | 1 | Array write request |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit and program cycle in progress |
| ptr_upd | output | 1 | One-cycle strobe: new address-counter value |
| ptr_value | output | 8 | New address-counter value |

## Verification
The hardest case to reach from the ports is a complete second transaction that arrives while a program cycle is still running. The bench opens a row-mode transaction and issues STOP. A few cycles later, while `busy` is high, it fires an address load, a data byte and another STOP. It then checks that the busy length equals one program time and that the second address still holds its reset value. Overflow wrap and the doubled program time are reached through table vectors whose start addresses sit just below a row or group edge, including a burst that wraps from FEh to 01h.

// File: rtl/eewb_pkg.sv
package eewb_pkg;
    typedef enum logic [1:0] {
        WB_IDLE,
        WB_COLLECT,
        WB_WRITE,
        WB_WAIT
    } wb_state_e;
endpackage

// File: rtl/eewb_slot_buf.sv
// Slot buffer: one {valid, address, data} entry per row byte.
module eewb_slot_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              slot_vld [SLOTS];
    logic [ADDR_W-1:0] slot_adr [SLOTS];
    logic [DATA_W-1:0] slot_dat [SLOTS];
    logic [SLOTS-1:0]  hit;

    // Decode the write index into one select line per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_hit
        assign hit[s] = wr_en && (wr_idx == IDX_W'(s));
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
                slot_adr[s] <= '0;
                slot_dat[s] <= '1;
            end else if (clear) begin
                slot_vld[s] <= 1'b0;
            end else if (hit[s]) begin
                slot_vld[s] <= 1'b1;
                slot_adr[s] <= wr_addr;
                slot_dat[s] <= wr_data;
            end
        end
    end

    assign rd_valid = slot_vld[rd_idx];
    assign rd_addr  = slot_adr[rd_idx];
    assign rd_data  = slot_dat[rd_idx];
endmodule

// File: rtl/eewb_addr_gen.sv
// Address arithmetic for both buffering modes.
module eewb_addr_gen #(
    parameter int ADDR_W   = 8,
    parameter int ROW_BITS = 3,
    parameter int MB_BITS  = 2,
    parameter int MB_LIMIT = 4,
    parameter int GRP_BITS = 2,
    parameter int CNT_W    = 4
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic                multi,
    input  logic [ROW_BITS-1:0] n_wrap,
    input  logic [CNT_W-1:0]    n_sat,
    output logic [ROW_BITS-1:0] slot_idx,
    output logic [ADDR_W-1:0]   byte_addr,
    output logic [ADDR_W-1:0]   next_addr,
    output logic                spans
);
    logic [ROW_BITS-1:0] pg_slot;
    logic [ADDR_W-1:0]   pg_addr;
    logic [MB_BITS-1:0]  mb_off;
    logic [CNT_W-1:0]    taken;
    logic [ADDR_W-1:0]   mb_last;

    always_comb begin
        // Row mode: only the offset inside the row advances.
        pg_slot = base[ROW_BITS-1:0] + n_wrap;
        pg_addr = {base[ADDR_W-1:ROW_BITS], pg_slot};

        // Burst mode: full-width increment, limited slot count.
        mb_off  = n_wrap[MB_BITS-1:0];
        taken   = (n_sat > CNT_W'(MB_LIMIT)) ? CNT_W'(MB_LIMIT) : n_sat;
        mb_last = base + ADDR_W'(taken) - ADDR_W'(1);

        if (multi) begin
            slot_idx  = ROW_BITS'(mb_off);
            byte_addr = base + ADDR_W'(mb_off);
            next_addr = base + ADDR_W'(taken);
            spans     = (taken != '0) &&
                        (mb_last[ADDR_W-1:GRP_BITS] != base[ADDR_W-1:GRP_BITS]);
        end else begin
            slot_idx  = pg_slot;
            byte_addr = pg_addr;
            next_addr = pg_addr;
            spans     = 1'b0;
        end
    end
endmodule

// File: rtl/eewb_prog_timer.sv
// Program-time counter: runs for BASE or 2*BASE cycles after start.
module eewb_prog_timer #(
    parameter int BASE_CYCLES = 1000,
    parameter int TW          = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dbl,
    output logic done
);
    logic          running;
    logic [TW-1:0] cnt;
    logic [TW-1:0] target;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            target  <= TW'(BASE_CYCLES);
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
            target  <= dbl ? TW'(2 * BASE_CYCLES) : TW'(BASE_CYCLES);
        end else if (running) begin
            if (cnt == target - TW'(1)) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt + TW'(1);
            end
        end
    end

    assign done = running && (cnt == target - TW'(1));
endmodule

// File: rtl/eeprom_wrbuf.sv
module eeprom_wrbuf
    import eewb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int ROW_BYTES   = 8,
    parameter int MB_LIMIT    = 4,
    parameter int GROUP_BYTES = 4,
    parameter int PROG_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mode_multi,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_seen,
    input  logic              write_ctl,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic              ptr_upd,
    output logic [ADDR_W-1:0] ptr_value
);
    localparam int ROW_BITS = $clog2(ROW_BYTES);
    localparam int MB_BITS  = $clog2(MB_LIMIT);
    localparam int GRP_BITS = $clog2(GROUP_BYTES);
    localparam int CNT_W    = $clog2(ROW_BYTES + 1);
    localparam int TW       = $clog2(2 * PROG_CYCLES + 1);

    wb_state_e           state_q, state_d;
    logic [ADDR_W-1:0]   base_q;
    logic                multi_q;
    logic [ROW_BITS-1:0] n_wrap_q;
    logic [CNT_W-1:0]    n_sat_q;
    logic [ROW_BITS-1:0] ptr_q;
    logic                span_q;
    logic                upd_q;
    logic [ADDR_W-1:0]   upd_addr_q;

    // Outputs of the state decoder
    logic take_load, buf_clear, buf_wr, close_txn, tmr_start, busy_c, we_c;

    // Datapath
    logic [ROW_BITS-1:0] slot_idx;
    logic [ADDR_W-1:0]   byte_addr, next_addr;
    logic                spans;
    logic                rd_valid;
    logic [ADDR_W-1:0]   rd_addr;
    logic [DATA_W-1:0]   rd_data;
    logic                tmr_done;

    eewb_addr_gen #(
        .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .MB_BITS(MB_BITS),
        .MB_LIMIT(MB_LIMIT), .GRP_BITS(GRP_BITS), .CNT_W(CNT_W)
    ) u_agen (
        .base(base_q), .multi(multi_q), .n_wrap(n_wrap_q), .n_sat(n_sat_q),
        .slot_idx(slot_idx), .byte_addr(byte_addr), .next_addr(next_addr),
        .spans(spans)
    );

    eewb_slot_buf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(ROW_BYTES), .IDX_W(ROW_BITS)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_wr),
        .wr_idx(slot_idx), .wr_addr(byte_addr), .wr_data(byte_data),
        .rd_idx(ptr_q), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    eewb_prog_timer #(
        .BASE_CYCLES(PROG_CYCLES), .TW(TW)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .dbl(span_q && multi_q), .done(tmr_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WB_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_IDLE: begin
                if (load_addr) state_d = WB_COLLECT;
            end
            WB_COLLECT: begin
                if (stop_seen) begin
                    state_d = ((n_sat_q != '0) && !write_ctl) ? WB_WRITE : WB_IDLE;
                end
            end
            WB_WRITE: begin
                if (ptr_q == ROW_BITS'(ROW_BYTES - 1)) state_d = WB_WAIT;
            end
            WB_WAIT: begin
                if (tmr_done) state_d = WB_IDLE;
            end
            default: state_d = WB_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        take_load = 1'b0;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        close_txn = 1'b0;
        tmr_start = 1'b0;
        busy_c    = 1'b0;
        we_c      = 1'b0;
        unique case (state_q)
            WB_IDLE: begin
                take_load = load_addr;
                buf_clear = load_addr;
            end
            WB_COLLECT: begin
                if (stop_seen) begin
                    close_txn = 1'b1;
                end else if (load_addr) begin
                    take_load = 1'b1;
                    buf_clear = 1'b1;
                end else if (byte_valid) begin
                    buf_wr = 1'b1;
                end
            end
            WB_WRITE: begin
                busy_c    = 1'b1;
                we_c      = rd_valid;
                tmr_start = (ptr_q == ROW_BITS'(ROW_BYTES - 1));
            end
            WB_WAIT: begin
                busy_c = 1'b1;
            end
            default: ;
        endcase
    end

    // Transaction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            multi_q    <= 1'b1;
            n_wrap_q   <= '0;
            n_sat_q    <= '0;
            ptr_q      <= '0;
            span_q     <= 1'b0;
            upd_q      <= 1'b0;
            upd_addr_q <= '0;
        end else begin
            upd_q <= close_txn;
            if (close_txn) begin
                upd_addr_q <= next_addr;
                span_q     <= spans;
                ptr_q      <= '0;
            end
            if (take_load) begin
                base_q   <= start_addr;
                multi_q  <= mode_multi;
                n_wrap_q <= '0;
                n_sat_q  <= '0;
            end
            if (buf_wr) begin
                n_wrap_q <= n_wrap_q + ROW_BITS'(1);
                if (n_sat_q != CNT_W'(ROW_BYTES)) n_sat_q <= n_sat_q + CNT_W'(1);
            end
            if (state_q == WB_WRITE) begin
                ptr_q <= ptr_q + ROW_BITS'(1);
            end
        end
    end

    assign arr_we    = we_c;
    assign arr_addr  = rd_addr;
    assign arr_wdata = rd_data;
    assign busy      = busy_c;
    assign ptr_upd   = upd_q;
    assign ptr_value = upd_addr_q;
endmodule

// File: rtl/eeprom_wrbuf_chk.sv
module eeprom_wrbuf_chk #(
    parameter int ADDR_W   = 8,
    parameter int ROW_BITS = 3,
    parameter int MB_LIMIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_addr,
    input logic              stop_seen,
    input logic              write_ctl,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              ptr_upd,
    input logic              multi_q,
    input logic [ADDR_W-1:0] base_q
);
    logic [ADDR_W-1:0] mb_dist;
    assign mb_dist = arr_addr - base_q;

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R7
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen)); // R7
    AST_WC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && write_ctl && !busy) |=> !busy); // R9
    AST_PAGE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !multi_q) |-> (arr_addr[ADDR_W-1:ROW_BITS] == base_q[ADDR_W-1:ROW_BITS])); // R2
    AST_MB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && multi_q) |-> (mb_dist < ADDR_W'(MB_LIMIT))); // R4
    AST_BUSY_HOLDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_addr) |=> $stable(base_q)); // R8
    AST_UPD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_upd |-> $past(stop_seen)); // R11
endmodule

bind eeprom_wrbuf eeprom_wrbuf_chk #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .MB_LIMIT(MB_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .stop_seen(stop_seen),
    .write_ctl(write_ctl), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .ptr_upd(ptr_upd), .multi_q(multi_q), .base_q(base_q)
);

// File: tb/eeprom_wrbuf_test.sv
`timescale 1ns/100ps
module eeprom_wrbuf_test;
    localparam int T   = 12;
    localparam int ROW = 8;
    localparam int MBL = 4;
    localparam int NV  = 10;
    // {mode_multi, write_ctl, byte count[3:0], start address[7:0]}
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'd8,  8'h10},
        {1'b0, 1'b0, 4'd5,  8'h25},
        {1'b0, 1'b0, 4'd11, 8'h3E},
        {1'b1, 1'b0, 4'd3,  8'h41},
        {1'b1, 1'b0, 4'd4,  8'h46},
        {1'b1, 1'b0, 4'd6,  8'h60},
        {1'b1, 1'b0, 4'd4,  8'hFE},
        {1'b0, 1'b1, 4'd3,  8'h80},
        {1'b1, 1'b0, 4'd0,  8'h90},
        {1'b0, 1'b0, 4'd1,  8'hC7}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_addr = 0, mode_multi = 0, byte_valid = 0, stop_seen = 0, write_ctl = 0;
    logic [7:0] start_addr = 0, byte_data = 0;
    logic arr_we, busy, ptr_upd;
    logic [7:0] arr_addr, arr_wdata, ptr_value;

    eeprom_wrbuf #(.PROG_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
        .mode_multi(mode_multi), .byte_valid(byte_valid), .byte_data(byte_data),
        .stop_seen(stop_seen), .write_ctl(write_ctl), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy),
        .ptr_upd(ptr_upd), .ptr_value(ptr_value)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    logic [7:0] model_mem [256];
    logic [7:0] dut_mem [256];
    int busy_cnt = 0, wr_cnt = 0;
    logic upd_seen = 0;
    logic [7:0] upd_val = 0;

    always @(negedge clk) begin
        if (arr_we) begin
            dut_mem[arr_addr] = arr_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (busy) busy_cnt = busy_cnt + 1;
        if (ptr_upd) begin
            upd_seen = 1'b1;
            upd_val  = ptr_value;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 256; i++) if (model_mem[i] !== dut_mem[i]) d++;
        return d;
    endfunction

    function automatic logic [7:0] dat(input int tag, input int k);
        return 8'(tag * 53 + k * 17 + 5);
    endfunction

    function automatic logic [7:0] exp_addr(input bit mb, input logic [7:0] a, input int k);
        if (mb) return 8'(a + 8'(k % MBL));
        return {a[7:3], 3'(a[2:0] + 3'(k))};
    endfunction

    function automatic string req_of(input int i);
        case (i)
            2: return "R3";
            3, 4, 6: return "R4";
            5: return "R5";
            7: return "R9";
            8: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic open_txn(input bit mb, input bit wc, input logic [7:0] a);
        @(negedge clk); #1;
        load_addr = 1; start_addr = a; mode_multi = mb; write_ctl = wc;
        @(negedge clk); #1;
        load_addr = 0;
    endtask

    task automatic send_bytes(input int n, input int tag);
        for (int k = 0; k < n; k++) begin
            byte_valid = 1; byte_data = dat(tag, k);
            @(negedge clk); #1;
        end
        byte_valid = 0;
    endtask

    task automatic pulse_stop();
        stop_seen = 1;
        @(negedge clk); #1;
        stop_seen = 0;
    endtask

    task automatic run_vec(input int idx, input bit mb, input bit wc, input int n, input logic [7:0] a);
        int taken, eb;
        bit span;
        logic [7:0] ep, last;
        wr_cnt = 0; busy_cnt = 0; upd_seen = 0;
        open_txn(mb, wc, a);
        send_bytes(n, idx);
        @(negedge clk);
        chk(wr_cnt == 0, "R7", "writes before STOP", wr_cnt, 0);
        #1 pulse_stop();
        if (!wc && n > 0)
            for (int k = 0; k < n; k++) model_mem[exp_addr(mb, a, k)] = dat(idx, k);
        repeat (ROW + 2 * T + 4) @(negedge clk);
        taken = (n > MBL) ? MBL : n;
        last  = 8'(a + 8'(taken) - 8'd1);
        span  = mb && taken > 0 && (last[7:2] != a[7:2]);
        eb    = (n > 0 && !wc) ? ROW + T * (span ? 2 : 1) : 0;
        ep    = mb ? 8'(a + 8'(taken)) : {a[7:3], 3'(a[2:0] + 3'(n))};
        chk(busy_cnt == eb, wc ? "R9" : (n == 0 ? "R10" : "R6"), "busy cycles", busy_cnt, eb);
        chk(upd_seen && upd_val == ep, "R11", "pointer update", int'(upd_val), int'(ep));
        chk(mem_diff() == 0, req_of(idx), "array mismatches", mem_diff(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 8'hFF;
            dut_mem[i]   = 8'hFF;
        end
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(arr_we == 0, "R1", "arr_we", arr_we, 0);
        chk(ptr_upd == 0, "R1", "ptr_upd", ptr_upd, 0);

        for (int i = 0; i < NV; i++)
            run_vec(i, VEC[i][13], VEC[i][12], int'(VEC[i][11:8]), VEC[i][7:0]);

        // R7: STOP and a byte with no open transaction do nothing
        busy_cnt = 0; wr_cnt = 0;
        #1 byte_valid = 1; byte_data = 8'h55;
        @(negedge clk); #1 byte_valid = 0;
        pulse_stop();
        repeat (ROW + 4) @(negedge clk);
        chk(busy_cnt == 0 && wr_cnt == 0, "R7", "idle STOP activity", busy_cnt + wr_cnt, 0);

        // R8: whole transaction issued while busy is ignored
        busy_cnt = 0; wr_cnt = 0;
        open_txn(1'b0, 1'b0, 8'hA0);
        send_bytes(2, 20);
        pulse_stop();
        for (int k = 0; k < 2; k++) model_mem[exp_addr(1'b0, 8'hA0, k)] = dat(20, k);
        repeat (3) @(negedge clk);
        chk(busy == 1, "R8", "busy during program", busy, 1);
        #1 load_addr = 1; start_addr = 8'hB0; mode_multi = 0;
        @(negedge clk); #1 load_addr = 0;
        send_bytes(1, 21);
        pulse_stop();
        repeat (ROW + 2 * T + 4) @(negedge clk);
        chk(busy_cnt == ROW + T, "R8", "busy cycles", busy_cnt, ROW + T);
        chk(wr_cnt == 2, "R8", "write count", wr_cnt, 2);
        chk(dut_mem[8'hB0] == 8'hFF && mem_diff() == 0, "R8", "ignored byte", int'(dut_mem[8'hB0]), 255);

        // follow-up transaction proceeds normally after the ignored one
        run_vec(9, 1'b0, 1'b0, 2, 8'hB0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule